// File: doc/BRIEF.md
# PWM Output Steering Controller

This block generates a single pulse-width-modulated waveform and distributes it onto any subset of four output pins. A pin that is selected for steering carries the waveform; a pin that is not selected carries a static bit held in a port-data register. The waveform comes from an internal counter that runs from zero up to a programmed period value and wraps. The waveform is high while the count is below a programmed duty value.

Software reaches the block through a simple register-write port. The port carries a 3-bit address and a data word. The block holds these registers:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 run, bit 1 boundary-aligned steering mode, bit 2 active-low for pins 0 and 2, bit 3 active-low for pins 1 and 3 |
| 1 | Steering mask, bits 3:0, one bit per pin |
| 2 | Port data, bits 3:0 |
| 3 | Period |
| 4 | Duty |

Steering changes take effect in one of two ways. In immediate mode they apply on the next clock, and a truncated pulse is accepted. In boundary-aligned mode they wait for the next period start, so that only whole pulses appear.

A startup interlock keeps all four output drivers disabled after reset and after every start of the waveform. The drivers stay disabled until one complete period has run. Inside the top module this interlock is a three-state machine:

- `GATE_OFF` is the stopped state.
- The machine moves from `GATE_OFF` to `GATE_FIRST` when run is set. It moves straight to `GATE_LIVE` if the first period is a single cycle long.
- It moves from `GATE_FIRST` to `GATE_LIVE` on the wrap that starts the second period.
- Any state returns to `GATE_OFF` when run is cleared.

Top module: `pwm_steer_ctrl`

## Requirements
- R1: After reset, `pin_oe` is 4'b0000 and `pin_out` is 4'b0000.
- R2: Each pin `i` outputs the (polarity-adjusted) waveform when steering mask bit `i` (address 1, bits 3:0) is 1, and outputs port-data bit `i` (address 2, bits 3:0) when the mask bit is 0.
- R3: When control bit 1 is 0, a write to the steering mask changes the pins on the clock edge that takes the write, even in mid-period.
- R4: When control bit 1 is 1 and the waveform is running, a steering write is held pending. It takes effect only at the edge where the count wraps from the period value to zero.
- R5: In boundary-aligned mode, a steering write taken on the same edge as a wrap takes effect at that wrap.
- R6: Control bit 2 inverts the waveform on pins 0 and 2, and control bit 3 inverts it on pins 1 and 3. Port-data bits are never inverted.
- R7: While running, the count goes 0, 1, ..., period and then back to 0. The waveform is high exactly while count < duty, so a duty of 0 is always low and a duty above the period is always high. While stopped, the waveform is low.
- R8: New period and duty values take effect only at a wrap, or at once while the waveform is stopped.
- R9: `pin_oe` is either all zeros or all ones. It turns to all ones only once the second period after setting run has begun.
- R10: Clearing run (control bit 0) forces `pin_oe` to zero on the next cycle and re-arms the interlock for the next start.
- R11: While stopped, a steering write takes effect on the next cycle even in boundary-aligned mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Write data |
| pin_out | output | 4 | Pin values |
| pin_oe | output | 4 | Pin output-driver enables |

## Verification
The bench places a boundary-aligned steering write on the exact cycle whose edge is a wrap. A design that applied the pending value before taking in the new write would show the old mask for a whole extra period.

It writes the mask in mid-period in both modes. A design that confused the two modes would either truncate pulses when it should not, or delay steering when it should not.

It times the interlock to the cycle after a start. This catches a release one period early or one period late, and it checks that a stop followed by a restart runs the full wait again.

It sets the duty to zero and above the period, and it uses polarity together with port data. An off-by-one compare, or an inversion leaking onto static pins, shows up at the pins.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;

    localparam int NPIN = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] REG_STEER  = 3'd1;
    localparam logic [ADDR_W-1:0] REG_PDATA  = 3'd2;
    localparam logic [ADDR_W-1:0] REG_PERIOD = 3'd3;
    localparam logic [ADDR_W-1:0] REG_DUTY   = 3'd4;

    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,
        GATE_FIRST = 2'd1,
        GATE_LIVE  = 2'd2
    } gate_state_t;

endpackage

// File: rtl/pwm_period_gen.sv
module pwm_period_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] duty_q,
    output logic             wrap,
    output logic             pwm
);

    // wrap marks the edge on which a new period begins
    assign wrap = run && (cnt_q == period_q);
    assign pwm  = run && (cnt_q < duty_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            period_q <= '0;
            duty_q   <= '0;
        end else if (!run || wrap) begin
            cnt_q    <= '0;
            period_q <= period_in;
            duty_q   <= duty_in;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/steer_sync_unit.sv
module steer_sync_unit #(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_steer,
    input  logic [NPIN-1:0] wr_value,
    input  logic            sync_mode,
    input  logic            apply,
    output logic [NPIN-1:0] steer_q
);

    logic [NPIN-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            steer_q <= '0;
        end else begin
            if (wr_steer) begin
                pend_q <= wr_value;
            end
            if (wr_steer && (!sync_mode || apply)) begin
                steer_q <= wr_value;
            end else if (sync_mode && apply) begin
                steer_q <= pend_q;
            end
        end
    end

endmodule

// File: rtl/startup_gate.sv
module startup_gate
    import pwm_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic wrap,
    output logic drv_on
);

    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_OFF: begin
                if (run) begin
                    state_d = wrap ? GATE_LIVE : GATE_FIRST;
                end
            end
            GATE_FIRST: begin
                if (!run) begin
                    state_d = GATE_OFF;
                end else if (wrap) begin
                    state_d = GATE_LIVE;
                end
            end
            GATE_LIVE: begin
                if (!run) begin
                    state_d = GATE_OFF;
                end
            end
            default: state_d = GATE_OFF;
        endcase
    end

    always_comb begin
        drv_on = (state_q == GATE_LIVE) && run;
    end

endmodule

// File: rtl/pwm_steer_ctrl.sv
module pwm_steer_ctrl
    import pwm_steer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe
);

    logic             run_q;
    logic             sync_q;
    logic [1:0]       pol_q;
    logic [NPIN-1:0]  pdata_q;
    logic [CNT_W-1:0] period_reg;
    logic [CNT_W-1:0] duty_reg;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] period_act;
    logic [CNT_W-1:0] duty_act;
    logic             wrap;
    logic             pwm;
    logic [NPIN-1:0]  steer_act;
    logic             drv_on;
    logic             wr_steer;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            sync_q     <= 1'b0;
            pol_q      <= '0;
            pdata_q    <= '0;
            period_reg <= '0;
            duty_reg   <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    run_q  <= wr_data[0];
                    sync_q <= wr_data[1];
                    pol_q  <= wr_data[3:2];
                end
                REG_PDATA:  pdata_q    <= wr_data[NPIN-1:0];
                REG_PERIOD: period_reg <= wr_data;
                REG_DUTY:   duty_reg   <= wr_data;
                default: ;
            endcase
        end
    end

    assign wr_steer = wr_en && (wr_addr == REG_STEER);

    pwm_period_gen #(.CNT_W(CNT_W)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_q),
        .period_in (period_reg),
        .duty_in   (duty_reg),
        .cnt_q     (cnt_q),
        .period_q  (period_act),
        .duty_q    (duty_act),
        .wrap      (wrap),
        .pwm       (pwm)
    );

    steer_sync_unit #(.NPIN(NPIN)) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_steer  (wr_steer),
        .wr_value  (wr_data[NPIN-1:0]),
        .sync_mode (sync_q),
        .apply     (wrap || !run_q),
        .steer_q   (steer_act)
    );

    startup_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_q),
        .wrap   (wrap),
        .drv_on (drv_on)
    );

    // pins 0/2 share polarity bit 0, pins 1/3 share bit 1
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        assign pin_out[i] = steer_act[i] ? (pwm ^ pol_q[i % 2]) : pdata_q[i];
        assign pin_oe[i]  = drv_on;
    end

endmodule

// File: rtl/pwm_steer_chk.sv
module pwm_steer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic [3:0]       pin_oe,
    input logic             run_q,
    input logic             sync_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] period_act,
    input logic             wrap,
    input logic [3:0]       steer_act
);

    a_r1_oe_off_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == 4'b0000));

    a_r9_oe_all_or_none: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == 4'b0000) || (pin_oe == 4'b1111));

    a_r10_oe_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (pin_oe == 4'b0000));

    a_r7_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= period_act));

    a_r8_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !wrap) |=> $stable(period_act));

    a_r4_steer_held: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && sync_q && !wrap) |=> $stable(steer_act));

    a_r3_steer_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 3'd1) && !sync_q) |=> (steer_act == $past(wr_data[3:0])));

endmodule

bind pwm_steer_ctrl pwm_steer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .pin_oe     (pin_oe),
    .run_q      (run_q),
    .sync_q     (sync_q),
    .cnt_q      (cnt_q),
    .period_act (period_act),
    .wrap       (wrap),
    .steer_act  (steer_act)
);

// File: tb/sim_pwm_steer_ctrl.sv
module sim_pwm_steer_ctrl;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [3:0]    pin_out;
    logic [3:0]    pin_oe;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // behavioural reference state
    int   m_cnt, m_pa, m_da, m_per, m_duty, m_phase;
    bit   m_en, m_sync;
    bit   [1:0] m_pol;
    logic [3:0] m_steer, m_pend, m_pd;

    always #10 clk = ~clk;

    pwm_steer_ctrl #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pa = 0; m_da = 0; m_per = 0; m_duty = 0; m_phase = 0;
            m_en = 0; m_sync = 0; m_pol = 0; m_steer = 0; m_pend = 0; m_pd = 0;
        end else begin
            bit w, app;
            w   = m_en && (m_cnt == m_pa);
            app = !m_en || w;
            if (m_en == 0) m_phase = 0;
            else if (m_phase == 0) m_phase = w ? 2 : 1;
            else if (m_phase == 1 && w) m_phase = 2;
            if (app) begin m_cnt = 0; m_pa = m_per; m_da = m_duty; end
            else m_cnt = m_cnt + 1;
            if (wr_en && wr_addr == 3'd1) begin
                m_pend = wr_data[3:0];
                if (!m_sync || app) m_steer = wr_data[3:0];
            end else if (m_sync && app) begin
                m_steer = m_pend;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_en = wr_data[0]; m_sync = wr_data[1]; m_pol = wr_data[3:2]; end
                    3'd2: m_pd = wr_data[3:0];
                    3'd3: m_per = int'(wr_data);
                    3'd4: m_duty = int'(wr_data);
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [3:0] exp_pins();
        logic [3:0] r;
        bit wave;
        wave = m_en && (m_cnt < m_da);
        for (int i = 0; i < 4; i++)
            r[i] = m_steer[i] ? (wave ^ m_pol[i % 2]) : m_pd[i];
        return r;
    endfunction

    function automatic logic [3:0] exp_oe();
        return (m_en && m_phase == 2) ? 4'hF : 4'h0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(pin_out === exp_pins(), cur_req, pin_out, exp_pins());
            check(pin_oe === exp_oe(), cur_req, pin_oe, exp_oe());
        end
    end

    task automatic wr(input logic [2:0] a, input int d);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pin_oe == 4'b0000, "R1", pin_oe, 4'b0000);
        check(pin_out == 4'b0000, "R1", pin_out, 4'b0000);

        cur_req = "R2";
        wr(3'd3, 4); wr(3'd4, 2); wr(3'd2, 4'b1010);
        check(pin_out == 4'b1010, "R2", pin_out, 4'b1010);

        cur_req = "R9";
        wr(3'd0, 4'b0001);
        repeat (4) @(negedge clk);
        check(pin_oe == 4'b0000, "R9", pin_oe, 4'b0000);
        @(negedge clk);
        check(pin_oe == 4'b1111, "R9", pin_oe, 4'b1111);

        cur_req = "R3";
        wr(3'd1, 4'b0011);
        check(pin_out == 4'b1011, "R3", pin_out, 4'b1011);

        cur_req = "R6";
        wr(3'd0, 4'b0101);
        check(pin_out == 4'b1001, "R6", pin_out, 4'b1001);
        repeat (12) @(negedge clk);

        cur_req = "R7";
        wr(3'd4, 0);
        repeat (12) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            check(pin_out[1] == 1'b0, "R7", {3'b0, pin_out[1]}, 4'b0000);
            @(negedge clk);
        end
        wr(3'd4, 7);
        repeat (12) @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            check(pin_out[1] == 1'b1, "R7", {3'b0, pin_out[1]}, 4'b0001);
            @(negedge clk);
        end

        cur_req = "R8";
        wr(3'd3, 9); wr(3'd4, 3);
        repeat (25) @(negedge clk);

        cur_req = "R4";
        wr(3'd0, 4'b0011);
        while (m_cnt != 1) @(negedge clk);
        wr(3'd1, 4'b1100);
        check(pin_out == 4'b1011, "R4", pin_out, 4'b1011);
        while (m_cnt != 0) @(negedge clk);
        check(pin_out == 4'b1110, "R4", pin_out, 4'b1110);

        cur_req = "R5";
        while (m_cnt != m_pa) @(negedge clk);
        wr(3'd1, 4'b0001);
        check(pin_out == 4'b1011, "R5", pin_out, 4'b1011);
        repeat (12) @(negedge clk);

        cur_req = "R10";
        wr(3'd0, 0);
        check(pin_oe == 4'b0000, "R10", pin_oe, 4'b0000);
        check(pin_out == 4'b1010, "R10", pin_out, 4'b1010);

        cur_req = "R11";
        wr(3'd0, 4'b0110);
        wr(3'd1, 4'b0100);
        check(pin_out == 4'b1110, "R11", pin_out, 4'b1110);

        cur_req = "R10";
        wr(3'd0, 4'b0011);
        repeat (9) @(negedge clk);
        check(pin_oe == 4'b0000, "R10", pin_oe, 4'b0000);
        @(negedge clk);
        check(pin_oe == 4'b1111, "R10", pin_oe, 4'b1111);
        repeat (20) @(negedge clk);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule